// File: doc/BRIEF.md
# Card Clock Phase Select Register

This block is the clock-phase control register of a card host clock unit. It holds three 3-bit fields: the phase at which receive data is sampled, the phase at which transmit data is driven, and a divider setting. It also holds a sticky wake-up flag, which hardware sets and firmware clears by writing a one to it. Firmware reaches the register through a plain single-cycle write strobe and a combinational read-back word.

Two timing words are presented on input pins: one for single data rate and one for double data rate. A load strobe copies one of them into the fields, chosen by the bus timing mode. A separate sample-only update changes only the sample phase, as a tuning sweep needs. The block also passes the outgoing command word through and forces its hold-select bit whenever the drive phase is non-zero. A zero drive phase lets commands bypass the hold register.

Top module: `cclk_sel_ctrl`

## Requirements
- R1: After reset, every field and the wake flag are zero. `reg_rdata_o` reads 0.
- R2: A write (`reg_wr_i`) sets the fields from the write data in the next cycle. The sample phase comes from bits 2:0, the drive phase from bits 18:16 and the divider from bits 26:24. `reg_rdata_o` returns the fields at the same positions.
- R3: Every read-back bit other than 2:0, 11, 18:16 and 26:24 reads 0, whatever was written there.
- R4: A `wake_evt_i` pulse sets the flag in read-back bit 11 in the next cycle. The flag stays set until it is cleared.
- R5: A write with bit 11 at 1 clears the flag. A write with bit 11 at 0 leaves the flag unchanged while the fields still take the written values. A wake event in the same cycle as a clearing write leaves the flag set.
- R6: `tmg_load_i` loads the fields from the timing presets in the next cycle. With `ddr_mode_i` at 1 it loads the DDR sample and drive phases, and with 0 it loads the SDR ones. The divider comes from `clk_div_i` in both modes. The wake flag is unchanged.
- R7: `smpl_upd_i` replaces only the sample phase, with `smpl_upd_val_i`. The drive phase, divider and flag keep their values.
- R8: `cmd_o` equals `cmd_i`, except that bit 29 is forced to 1 while the drive phase is non-zero. `hold_sel_o` shows the same condition. This path is combinational from the current register state.
- R9: When update strobes coincide, a register write takes priority over a timing load, and a timing load takes priority over a sample-only update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read-back |
| smpl_upd_i | input | 1 | Sample-only update strobe |
| smpl_upd_val_i | input | 3 | New sample phase |
| tmg_load_i | input | 1 | Load timing preset strobe |
| ddr_mode_i | input | 1 | Bus timing mode is DDR |
| sdr_smpl_i | input | 3 | SDR preset sample phase |
| sdr_drv_i | input | 3 | SDR preset drive phase |
| ddr_smpl_i | input | 3 | DDR preset sample phase |
| ddr_drv_i | input | 3 | DDR preset drive phase |
| clk_div_i | input | 3 | Preset divider, shared by both modes |
| wake_evt_i | input | 1 | Wake event, sets the flag |
| cmd_i | input | 32 | Outgoing command word |
| cmd_o | output | 32 | Command word with the hold-select bit applied |
| smpl_ph_o | output | 3 | Current sample phase |
| drv_ph_o | output | 3 | Current drive phase |
| div_o | output | 3 | Current divider |
| wake_flag_o | output | 1 | Wake flag |
| hold_sel_o | output | 1 | Commands use the hold register |

## Verification
The hardest case to reach is the one where a wake event and a clearing write arrive in the same cycle. The bench forces it by raising both strobes at one falling edge, then checks read-back bit 11 after the following rising edge. A write with bit 11 at 0 is the other subtle case. The bench first arms the flag, then writes new fields with bit 11 low, and checks that the fields moved while the flag held. Every one of the 512 field combinations is written, with the unused bits alternately all ones and all zeros. Each write checks the read-back and the command hold bit.

// File: rtl/cclk_sel_pkg.sv
package cclk_sel_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned PH_W     = 3;
  localparam int unsigned SMPL_LSB = 0;
  localparam int unsigned WAKE_BIT = 11;
  localparam int unsigned DRV_LSB  = 16;
  localparam int unsigned DIV_LSB  = 24;
  localparam int unsigned HOLD_BIT = 29;

  typedef struct packed {
    logic [PH_W-1:0] div;
    logic [PH_W-1:0] drv;
    logic [PH_W-1:0] smpl;
  } ph_fields_t;

  function automatic ph_fields_t unpack_word(logic [REG_W-1:0] w);
    ph_fields_t f;
    f.smpl = w[SMPL_LSB +: PH_W];
    f.drv  = w[DRV_LSB  +: PH_W];
    f.div  = w[DIV_LSB  +: PH_W];
    return f;
  endfunction

  function automatic logic [REG_W-1:0] pack_word(ph_fields_t f, logic wake);
    logic [REG_W-1:0] w;
    w = '0;
    w[SMPL_LSB +: PH_W] = f.smpl;
    w[DRV_LSB  +: PH_W] = f.drv;
    w[DIV_LSB  +: PH_W] = f.div;
    w[WAKE_BIT]         = wake;
    return w;
  endfunction
endpackage

// File: rtl/cclk_sel_timing.sv
module cclk_sel_timing
  import cclk_sel_pkg::*;
(
  input  logic            ddr_mode_i,
  input  logic [PH_W-1:0] sdr_smpl_i,
  input  logic [PH_W-1:0] sdr_drv_i,
  input  logic [PH_W-1:0] ddr_smpl_i,
  input  logic [PH_W-1:0] ddr_drv_i,
  input  logic [PH_W-1:0] clk_div_i,
  output ph_fields_t      word_o
);
  always_comb begin
    word_o.div = clk_div_i;
    if (ddr_mode_i) begin
      word_o.smpl = ddr_smpl_i;
      word_o.drv  = ddr_drv_i;
    end else begin
      word_o.smpl = sdr_smpl_i;
      word_o.drv  = sdr_drv_i;
    end
  end
endmodule

// File: rtl/cclk_sel_fields.sv
module cclk_sel_fields
  import cclk_sel_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  ph_fields_t      wr_f_i,
  input  logic            ld_en_i,
  input  ph_fields_t      ld_f_i,
  input  logic            smpl_en_i,
  input  logic [PH_W-1:0] smpl_i,
  output ph_fields_t      f_o
);
  ph_fields_t f_q;

  // write > preset load > sample-only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        f_q <= '0;
    else if (wr_en_i)   f_q <= wr_f_i;
    else if (ld_en_i)   f_q <= ld_f_i;
    else if (smpl_en_i) f_q.smpl <= smpl_i;
  end

  assign f_o = f_q;
endmodule

// File: rtl/cclk_sel_wake.sv
module cclk_sel_wake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cclk_sel_cmd_hold.sv
module cclk_sel_cmd_hold #(
  parameter int unsigned CMD_W    = 32,
  parameter int unsigned PH_W     = 3,
  parameter int unsigned HOLD_BIT = 29
) (
  input  logic [PH_W-1:0]  drv_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             hold_o
);
  assign hold_o = |drv_i;

  for (genvar b = 0; b < CMD_W; b++) begin : g_bit
    if (b == HOLD_BIT) begin : g_hold
      assign cmd_o[b] = cmd_i[b] | hold_o;
    end else begin : g_pass
      assign cmd_o[b] = cmd_i[b];
    end
  end
endmodule

// File: rtl/cclk_sel_ctrl.sv
module cclk_sel_ctrl
  import cclk_sel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             smpl_upd_i,
  input  logic [PH_W-1:0]  smpl_upd_val_i,
  input  logic             tmg_load_i,
  input  logic             ddr_mode_i,
  input  logic [PH_W-1:0]  sdr_smpl_i,
  input  logic [PH_W-1:0]  sdr_drv_i,
  input  logic [PH_W-1:0]  ddr_smpl_i,
  input  logic [PH_W-1:0]  ddr_drv_i,
  input  logic [PH_W-1:0]  clk_div_i,
  input  logic             wake_evt_i,
  input  logic [REG_W-1:0] cmd_i,
  output logic [REG_W-1:0] cmd_o,
  output logic [PH_W-1:0]  smpl_ph_o,
  output logic [PH_W-1:0]  drv_ph_o,
  output logic [PH_W-1:0]  div_o,
  output logic             wake_flag_o,
  output logic             hold_sel_o
);
  ph_fields_t preset_w, wr_f_w, cur_f_w;
  logic       flag_w;

  assign wr_f_w = unpack_word(reg_wdata_i);

  cclk_sel_timing u_timing (
    .ddr_mode_i (ddr_mode_i),
    .sdr_smpl_i (sdr_smpl_i),
    .sdr_drv_i  (sdr_drv_i),
    .ddr_smpl_i (ddr_smpl_i),
    .ddr_drv_i  (ddr_drv_i),
    .clk_div_i  (clk_div_i),
    .word_o     (preset_w)
  );

  cclk_sel_fields u_fields (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (reg_wr_i),
    .wr_f_i    (wr_f_w),
    .ld_en_i   (tmg_load_i),
    .ld_f_i    (preset_w),
    .smpl_en_i (smpl_upd_i),
    .smpl_i    (smpl_upd_val_i),
    .f_o       (cur_f_w)
  );

  cclk_sel_wake u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wake_evt_i),
    .clr_i  (reg_wr_i & reg_wdata_i[WAKE_BIT]),
    .flag_o (flag_w)
  );

  cclk_sel_cmd_hold #(
    .CMD_W    (REG_W),
    .PH_W     (PH_W),
    .HOLD_BIT (HOLD_BIT)
  ) u_cmd_hold (
    .drv_i  (cur_f_w.drv),
    .cmd_i  (cmd_i),
    .cmd_o  (cmd_o),
    .hold_o (hold_sel_o)
  );

  assign reg_rdata_o = pack_word(cur_f_w, flag_w);
  assign smpl_ph_o   = cur_f_w.smpl;
  assign drv_ph_o    = cur_f_w.drv;
  assign div_o       = cur_f_w.div;
  assign wake_flag_o = flag_w;
endmodule

// File: rtl/cclk_sel_ctrl_chk.sv
module cclk_sel_ctrl_chk
  import cclk_sel_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             smpl_upd_i,
  input logic [PH_W-1:0]  smpl_upd_val_i,
  input logic             tmg_load_i,
  input logic             ddr_mode_i,
  input logic [PH_W-1:0]  ddr_smpl_i,
  input logic [PH_W-1:0]  sdr_smpl_i,
  input logic             wake_evt_i,
  input logic [REG_W-1:0] cmd_i,
  input logic [REG_W-1:0] cmd_o,
  input logic [PH_W-1:0]  smpl_ph_o,
  input logic [PH_W-1:0]  drv_ph_o,
  input logic [PH_W-1:0]  div_o,
  input logic             wake_flag_o
);
  localparam logic [REG_W-1:0] UNUSED_M = ~((((REG_W)'(1) << PH_W) - 1) << SMPL_LSB |
                                            (((REG_W)'(1) << PH_W) - 1) << DRV_LSB  |
                                            (((REG_W)'(1) << PH_W) - 1) << DIV_LSB  |
                                            ((REG_W)'(1) << WAKE_BIT));

  p_unused_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & UNUSED_M) == '0);

  p_wake_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_evt_i |=> wake_flag_o);

  p_wake_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_flag_o && !(reg_wr_i && reg_wdata_i[WAKE_BIT])) |=> wake_flag_o);

  p_wake_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_wdata_i[WAKE_BIT] && !wake_evt_i) |=> !wake_flag_o);

  p_preset_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmg_load_i && !reg_wr_i) |=>
      smpl_ph_o == ($past(ddr_mode_i) ? $past(ddr_smpl_i) : $past(sdr_smpl_i)));

  p_smpl_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smpl_upd_i && !reg_wr_i && !tmg_load_i) |=>
      (smpl_ph_o == $past(smpl_upd_val_i)) && $stable(drv_ph_o) && $stable(div_o));

  p_hold_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_ph_o != '0) |-> cmd_o[HOLD_BIT]);

  p_hold_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_ph_o == '0) |-> (cmd_o == cmd_i));

  p_write_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> drv_ph_o == $past(reg_wdata_i[DRV_LSB +: PH_W]));
endmodule

bind cclk_sel_ctrl cclk_sel_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_wr_i       (reg_wr_i),
  .reg_wdata_i    (reg_wdata_i),
  .reg_rdata_o    (reg_rdata_o),
  .smpl_upd_i     (smpl_upd_i),
  .smpl_upd_val_i (smpl_upd_val_i),
  .tmg_load_i     (tmg_load_i),
  .ddr_mode_i     (ddr_mode_i),
  .ddr_smpl_i     (ddr_smpl_i),
  .sdr_smpl_i     (sdr_smpl_i),
  .wake_evt_i     (wake_evt_i),
  .cmd_i          (cmd_i),
  .cmd_o          (cmd_o),
  .smpl_ph_o      (smpl_ph_o),
  .drv_ph_o       (drv_ph_o),
  .div_o          (div_o),
  .wake_flag_o    (wake_flag_o)
);

// File: tb/cclk_sel_ctrl_tb.sv
module cclk_sel_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        smpl_upd = 1'b0;
  logic [2:0]  smpl_val = '0;
  logic        tmg_load = 1'b0;
  logic        ddr_mode = 1'b0;
  logic [2:0]  sdr_smpl = '0, sdr_drv = '0, ddr_smpl = '0, ddr_drv = '0, clk_div = '0;
  logic        wake_evt = 1'b0;
  logic [31:0] cmd_in = '0;
  logic [31:0] cmd_out;
  logic [2:0]  smpl_ph, drv_ph, div_ph;
  logic        wake_flag, hold_sel;

  int n_chk = 0;
  int n_fail = 0;
  logic [2:0] e_smpl = '0, e_drv = '0, e_div = '0;
  logic       e_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cclk_sel_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .smpl_upd_i(smpl_upd), .smpl_upd_val_i(smpl_val),
    .tmg_load_i(tmg_load), .ddr_mode_i(ddr_mode), .sdr_smpl_i(sdr_smpl),
    .sdr_drv_i(sdr_drv), .ddr_smpl_i(ddr_smpl), .ddr_drv_i(ddr_drv),
    .clk_div_i(clk_div), .wake_evt_i(wake_evt), .cmd_i(cmd_in), .cmd_o(cmd_out),
    .smpl_ph_o(smpl_ph), .drv_ph_o(drv_ph), .div_o(div_ph),
    .wake_flag_o(wake_flag), .hold_sel_o(hold_sel)
  );

  function automatic logic [31:0] exp_word();
    return {5'b0, e_div, 5'b0, e_drv, 4'b0, e_flag, 8'b0, e_smpl};
  endfunction

  function automatic logic [31:0] mk_word(logic [2:0] s, logic [2:0] d, logic [2:0] v,
                                          logic w, logic junk);
    logic [31:0] x;
    x = junk ? 32'hF8F8_F7F8 : 32'h0;
    x[2:0] = s; x[18:16] = d; x[26:24] = v; x[11] = w;
    return x;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive one write, advance one cycle, update model
  task automatic do_write(logic [31:0] w, logic evt);
    reg_wr = 1'b1; reg_wdata = w; wake_evt = evt;
    @(negedge clk);
    reg_wr = 1'b0; wake_evt = 1'b0;
    e_smpl = w[2:0]; e_drv = w[18:16]; e_div = w[26:24];
    e_flag = evt | (e_flag & ~w[11]);
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", reg_rdata, 32'h0);
    chk("R1 reset cmd", cmd_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R8: every field combination, alternating junk in unused bits
    for (int i = 0; i < 512; i++) begin
      do_write(mk_word(i[2:0], i[5:3], i[8:6], 1'b0, i[0]), 1'b0);
      chk("R2 R3 field write", reg_rdata, exp_word());
      cmd_in = 32'h0;
      #1;
      chk("R8 hold bit", cmd_out, (e_drv != 0) ? 32'h2000_0000 : 32'h0);
      chk("R8 hold out", {31'b0, hold_sel}, {31'b0, e_drv != 0});
    end

    // R8 pass-through patterns
    do_write(mk_word(3'd4, 3'd0, 3'd1, 1'b0, 1'b0), 1'b0);
    cmd_in = 32'hDFFF_FFFF; #1;
    chk("R8 pass zero drv", cmd_out, 32'hDFFF_FFFF);
    cmd_in = 32'h2000_0000; #1;
    chk("R8 pass bit29", cmd_out, 32'h2000_0000);
    do_write(mk_word(3'd4, 3'd5, 3'd1, 1'b0, 1'b0), 1'b0);
    cmd_in = 32'h1234_5678; #1;
    chk("R8 force bit29", cmd_out, 32'h3234_5678);

    // R4 wake set and stick
    wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0; e_flag = 1'b1;
    chk("R4 wake set", reg_rdata, exp_word());
    repeat (3) @(negedge clk);
    chk("R4 wake sticky", reg_rdata, exp_word());
    // R5 write 0 to bit 11: fields move, flag holds
    do_write(mk_word(3'd2, 3'd6, 3'd7, 1'b0, 1'b1), 1'b0);
    chk("R5 write zero keeps flag", reg_rdata, exp_word());
    chk("R5 flag still set", {31'b0, wake_flag}, 32'h1);
    // R5 clear
    do_write(mk_word(3'd2, 3'd6, 3'd7, 1'b1, 1'b0), 1'b0);
    chk("R5 clear", reg_rdata, exp_word());
    chk("R5 flag cleared", {31'b0, wake_flag}, 32'h0);
    // R5 set and clear together
    wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0; e_flag = 1'b1;
    do_write(mk_word(3'd1, 3'd1, 3'd1, 1'b1, 1'b0), 1'b1);
    chk("R5 set beats clear", reg_rdata, exp_word());
    chk("R5 flag after race", {31'b0, wake_flag}, 32'h1);

    // R6 preset load in both modes; flag stays set
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 8; v++) begin
        sdr_smpl = 3'(v); sdr_drv = 3'(7 - v);
        ddr_smpl = 3'(v + 3); ddr_drv = 3'(v + 5); clk_div = 3'(v) ^ 3'd5;
        ddr_mode = m[0]; tmg_load = 1'b1;
        @(negedge clk);
        tmg_load = 1'b0;
        e_smpl = m[0] ? 3'(v + 3) : 3'(v);
        e_drv  = m[0] ? 3'(v + 5) : 3'(7 - v);
        e_div  = 3'(v) ^ 3'd5;
        chk(m[0] ? "R6 ddr load" : "R6 sdr load", reg_rdata, exp_word());
      end
    end

    // R7 sample-only sweep
    do_write(mk_word(3'd0, 3'd6, 3'd3, 1'b0, 1'b0), 1'b0);
    for (int s = 0; s < 8; s++) begin
      smpl_val = 3'(7 - s); smpl_upd = 1'b1;
      @(negedge clk);
      smpl_upd = 1'b0; e_smpl = 3'(7 - s);
      chk("R7 sample only", reg_rdata, exp_word());
    end

    // R9 priority
    sdr_smpl = 3'd1; sdr_drv = 3'd2; clk_div = 3'd3; ddr_mode = 1'b0;
    smpl_val = 3'd7;
    reg_wr = 1'b1; reg_wdata = mk_word(3'd5, 3'd4, 3'd6, 1'b0, 1'b0);
    tmg_load = 1'b1; smpl_upd = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    e_smpl = 3'd5; e_drv = 3'd4; e_div = 3'd6;
    chk("R9 write beats load", reg_rdata, exp_word());
    @(negedge clk);
    tmg_load = 1'b0; smpl_upd = 1'b0;
    e_smpl = 3'd1; e_drv = 3'd2; e_div = 3'd3;
    chk("R9 load beats sample", reg_rdata, exp_word());

    // R1 reset again, asynchronously
    rst_n = 1'b0; #1;
    chk("R1 async reset", reg_rdata, 32'h0);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule